// File: doc/BRIEF.md
# Indirect table access port

This block gives software a two-register window onto a set of small internal tables. A 64-bit address register selects a table, an entry index within it, and whether the index should step forward after each access. A 64-bit data register then reads or writes the selected entry. Both registers sit on a simple request/response register bus. Requests are always accepted, and read data returns one cycle after the request.

Each table has its own index mask, so an index that is out of range folds back into the table. With auto-increment enabled, the index wraps inside that mask. Some select codes name tables that have no storage behind them. These still mask and advance the index, read as zero and drop writes. Select codes that name no table raise an error pulse and leave everything unchanged.

Two tables have side effects on write:
- A write to the interrupt-vector table keeps only its defined fields and announces the entry on a strobe.
- A write to the 64-bit window table announces the changed index on a strobe.

Top module: `itab_port`

## Requirements
- R1: The address register resets to zero and reads back whatever was last written to it, updated by any index advance. Its fields are: auto-increment flag at bit 63, table select at bits [51:48], entry index at bits [8:0].
- R2: A data read or write reaches the entry of the selected table at (index AND table mask), using the index as it stood before any advance.
- R3: When the auto-increment flag is set, every data access to a known select writes (masked index + 1) AND mask back into the index field. When the flag is clear, the address register is left untouched.
- R4: The select codes with storage, and their masks, are: 0 = list table (7), 1 = interrupt-vector table (7), 4 = window table (15), 5 = map table (255), 6 = translation table (511), 7 = event table (3).
- R5: Select codes 2 (mask 31), 3 (mask 63) and 8 (mask 255) have no storage. They mask and advance the index as in R3, read as zero, and drop writes.
- R6: Select codes 9 to 15 are unknown. A data access to them reads zero, changes no table and leaves the address register unchanged. It pulses sel_err_o for one cycle, one cycle after the access.
- R7: A write to the interrupt-vector table stores only the server field [31:24], the priority field [23:16] and the node field [3:0]. All other bits read back as zero.
- R8: One cycle after a write to the interrupt-vector table, ivt_upd_o pulses with the following values:
  - ivt_idx_o: the entry index.
  - ivt_server_o: the stored server field shifted right by 2 (bits [31:26]).
  - ivt_prio_o: the stored priority field.
- R9: One cycle after a write to the window table, win_chg_o pulses with the written index on win_idx_o. No other write raises it.
- R10: req_ready_o is always high. Every read request yields exactly one rsp_valid_o pulse in the following cycle, and writes yield none.
- R11: All table entries reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_data_sel_i | input | 1 | 0 = address register, 1 = data register |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| sel_err_o | output | 1 | Access to unknown table select |
| ivt_upd_o | output | 1 | Interrupt-vector entry written |
| ivt_idx_o | output | 9 | Index of written interrupt-vector entry |
| ivt_server_o | output | 6 | Server number sent onward |
| ivt_prio_o | output | 8 | Priority of written entry |
| win_chg_o | output | 1 | Window table entry changed |
| win_idx_o | output | 9 | Index of changed window entry |

## Verification
The entry access and the index advance happen on the same clock edge. A read must return the entry at the old index while the address register already holds the new one. The bench provokes this with back-to-back data reads and writes that cross each table's wrap point. It compares every returned word, and a following address-register read, against a reference model that applies the access first and the advance second. Writes to the two side-effect tables land in the same cycle as an index advance, so their strobes are checked to carry the pre-advance index.

// File: rtl/itab_pkg.sv
package itab_pkg;
  localparam int AINC_BIT = 63;
  localparam int SEL_LSB  = 48;
  localparam int SEL_W    = 4;
  localparam int IDX_LSB  = 0;
  localparam int DATA_W   = 64;

  typedef enum logic [SEL_W-1:0] {
    TS_LIST = 4'd0,
    TS_IVT  = 4'd1,
    TS_CAM  = 4'd2,
    TS_RCAM = 4'd3,
    TS_WIN  = 4'd4,
    TS_MAP  = 4'd5,
    TS_XLT  = 4'd6,
    TS_EVT  = 4'd7,
    TS_PEST = 4'd8
  } tsel_e;

  // storage slots
  localparam int SLOT_LIST = 0;
  localparam int SLOT_IVT  = 1;
  localparam int SLOT_WIN  = 2;
  localparam int SLOT_MAP  = 3;
  localparam int SLOT_XLT  = 4;
  localparam int SLOT_EVT  = 5;
  localparam int NSTOR     = 6;

  localparam logic [DATA_W-1:0] IVT_KEEP = 64'h0000_0000_FFFF_000F;
  localparam int IVT_SRV_LSB = 24;
  localparam int IVT_PRI_LSB = 16;
  localparam int SRV_OUT_W   = 6;
  localparam int PRI_W       = 8;
endpackage

// File: rtl/itab_decode.sv
module itab_decode
  import itab_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int LIST_D = 8,
  parameter int IVT_D  = 8,
  parameter int WIN_D  = 16,
  parameter int MAP_D  = 256,
  parameter int XLT_D  = 512,
  parameter int EVT_D  = 4,
  parameter int CAM_D  = 32,
  parameter int RCAM_D = 64,
  parameter int PEST_D = 256
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             known_o,
  output logic             stored_o,
  output logic [2:0]       slot_o,
  output logic [IDX_W-1:0] mask_o
);
  always_comb begin
    known_o  = 1'b1;
    stored_o = 1'b1;
    slot_o   = 3'd0;
    mask_o   = '0;
    case (sel_i)
      TS_LIST: begin slot_o = 3'(SLOT_LIST); mask_o = IDX_W'(LIST_D - 1); end
      TS_IVT:  begin slot_o = 3'(SLOT_IVT);  mask_o = IDX_W'(IVT_D - 1);  end
      TS_WIN:  begin slot_o = 3'(SLOT_WIN);  mask_o = IDX_W'(WIN_D - 1);  end
      TS_MAP:  begin slot_o = 3'(SLOT_MAP);  mask_o = IDX_W'(MAP_D - 1);  end
      TS_XLT:  begin slot_o = 3'(SLOT_XLT);  mask_o = IDX_W'(XLT_D - 1);  end
      TS_EVT:  begin slot_o = 3'(SLOT_EVT);  mask_o = IDX_W'(EVT_D - 1);  end
      TS_CAM:  begin stored_o = 1'b0; mask_o = IDX_W'(CAM_D - 1);  end
      TS_RCAM: begin stored_o = 1'b0; mask_o = IDX_W'(RCAM_D - 1); end
      TS_PEST: begin stored_o = 1'b0; mask_o = IDX_W'(PEST_D - 1); end
      default: begin known_o = 1'b0; stored_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/itab_store.sv
module itab_store #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/itab_effects.sv
module itab_effects
  import itab_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    st_wdata_o,
  output logic                 ivt_upd_o,
  output logic [IDX_W-1:0]     ivt_idx_o,
  output logic [SRV_OUT_W-1:0] ivt_server_o,
  output logic [PRI_W-1:0]     ivt_prio_o,
  output logic                 win_chg_o,
  output logic [IDX_W-1:0]     win_idx_o
);
  logic is_ivt, is_win;

  assign is_ivt     = (sel_i == TS_IVT);
  assign is_win     = (sel_i == TS_WIN);
  assign st_wdata_o = is_ivt ? (wdata_i & IVT_KEEP) : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivt_upd_o    <= 1'b0;
      ivt_idx_o    <= '0;
      ivt_server_o <= '0;
      ivt_prio_o   <= '0;
      win_chg_o    <= 1'b0;
      win_idx_o    <= '0;
    end else begin
      ivt_upd_o <= wr_i & is_ivt;
      win_chg_o <= wr_i & is_win;
      if (wr_i && is_ivt) begin
        ivt_idx_o    <= idx_i;
        // low two server bits are a link pointer, not part of the number
        ivt_server_o <= st_wdata_o[IVT_SRV_LSB+2 +: SRV_OUT_W];
        ivt_prio_o   <= st_wdata_o[IVT_PRI_LSB +: PRI_W];
      end
      if (wr_i && is_win) win_idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/itab_port.sv
module itab_port
  import itab_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int LIST_D = 8,
  parameter int IVT_D  = 8,
  parameter int WIN_D  = 16,
  parameter int MAP_D  = 256,
  parameter int XLT_D  = 512,
  parameter int EVT_D  = 4,
  parameter int CAM_D  = 32,
  parameter int RCAM_D = 64,
  parameter int PEST_D = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic                 req_data_sel_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic                 sel_err_o,
  output logic                 ivt_upd_o,
  output logic [IDX_W-1:0]     ivt_idx_o,
  output logic [SRV_OUT_W-1:0] ivt_server_o,
  output logic [PRI_W-1:0]     ivt_prio_o,
  output logic                 win_chg_o,
  output logic [IDX_W-1:0]     win_idx_o
);
  logic [DATA_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  raw_idx, cur_idx, nxt_idx, mask;
  logic              ainc, known, stored;
  logic [2:0]        slot;
  logic              data_acc, addr_wr, tbl_we;
  logic [DATA_W-1:0] st_wdata, tbl_rd;
  logic [DATA_W-1:0] rd_arr [NSTOR];

  assign req_ready_o = 1'b1;
  assign sel     = addr_q[SEL_LSB +: SEL_W];
  assign raw_idx = addr_q[IDX_LSB +: IDX_W];
  assign ainc    = addr_q[AINC_BIT];

  itab_decode #(
    .IDX_W(IDX_W), .LIST_D(LIST_D), .IVT_D(IVT_D), .WIN_D(WIN_D),
    .MAP_D(MAP_D), .XLT_D(XLT_D), .EVT_D(EVT_D), .CAM_D(CAM_D),
    .RCAM_D(RCAM_D), .PEST_D(PEST_D)
  ) u_dec (
    .sel_i   (sel),
    .known_o (known),
    .stored_o(stored),
    .slot_o  (slot),
    .mask_o  (mask)
  );

  assign cur_idx  = raw_idx & mask;
  assign nxt_idx  = (cur_idx + IDX_W'(1)) & mask;
  assign data_acc = req_valid_i & req_data_sel_i;
  assign addr_wr  = req_valid_i & req_write_i & ~req_data_sel_i;
  assign tbl_we   = data_acc & req_write_i & known & stored;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_wr) begin
      addr_q <= req_wdata_i;
    end else if (data_acc && known && ainc) begin
      addr_q[IDX_LSB +: IDX_W] <= nxt_idx;
    end
  end

  itab_effects #(.IDX_W(IDX_W)) u_fx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (tbl_we),
    .sel_i       (sel),
    .idx_i       (cur_idx),
    .wdata_i     (req_wdata_i),
    .st_wdata_o  (st_wdata),
    .ivt_upd_o   (ivt_upd_o),
    .ivt_idx_o   (ivt_idx_o),
    .ivt_server_o(ivt_server_o),
    .ivt_prio_o  (ivt_prio_o),
    .win_chg_o   (win_chg_o),
    .win_idx_o   (win_idx_o)
  );

  for (genvar k = 0; k < NSTOR; k++) begin : g_tbl
    localparam int DEP = (k == SLOT_LIST) ? LIST_D :
                         (k == SLOT_IVT)  ? IVT_D  :
                         (k == SLOT_WIN)  ? WIN_D  :
                         (k == SLOT_MAP)  ? MAP_D  :
                         (k == SLOT_XLT)  ? XLT_D  : EVT_D;
    localparam int AW = (DEP > 1) ? $clog2(DEP) : 1;
    logic we;
    assign we = tbl_we & (slot == 3'(k));
    itab_store #(.DEPTH(DEP), .W(DATA_W)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .idx_i  (cur_idx[AW-1:0]),
      .wdata_i(st_wdata),
      .rdata_o(rd_arr[k])
    );
  end

  always_comb begin
    tbl_rd = '0;
    if (known && stored) begin
      for (int k = 0; k < NSTOR; k++) begin
        if (slot == 3'(k)) tbl_rd = rd_arr[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      sel_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i & ~req_write_i;
      if (req_valid_i && !req_write_i)
        rsp_rdata_o <= req_data_sel_i ? tbl_rd : addr_q;
      sel_err_o <= data_acc & ~known;
    end
  end
endmodule

// File: rtl/itab_port_chk.sv
module itab_port_chk
  import itab_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_data_sel_i,
  input logic              rsp_valid_o,
  input logic              sel_err_o,
  input logic              ivt_upd_o,
  input logic              win_chg_o,
  input logic [DATA_W-1:0] addr_q
);
  logic [SEL_W-1:0] sel_now;
  logic             unk_acc;

  assign sel_now = addr_q[SEL_LSB +: SEL_W];
  assign unk_acc = req_valid_i && req_data_sel_i && (sel_now > 4'd8);

  assert_rsp_follows_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_no_rsp_without_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

  assert_err_from_unknown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_acc |=> sel_err_o);

  assert_unknown_keeps_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_acc |=> $stable(addr_q));

  assert_noinc_keeps_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_data_sel_i && !addr_q[AINC_BIT]) |=> $stable(addr_q));

  assert_win_strobe_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_chg_o |-> $past(req_valid_i && req_write_i && req_data_sel_i && sel_now == TS_WIN));

  assert_ivt_strobe_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivt_upd_o |-> $past(req_valid_i && req_write_i && req_data_sel_i && sel_now == TS_IVT));

  assert_single_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_err_o, ivt_upd_o, win_chg_o}));
endmodule

bind itab_port itab_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_write_i   (req_write_i),
  .req_data_sel_i(req_data_sel_i),
  .rsp_valid_o   (rsp_valid_o),
  .sel_err_o     (sel_err_o),
  .ivt_upd_o     (ivt_upd_o),
  .win_chg_o     (win_chg_o),
  .addr_q        (addr_q)
);

// File: tb/itab_port_tb.sv
module itab_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dsel = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, sel_err, ivt_upd, win_chg;
  logic [63:0] rsp_rdata;
  logic [8:0]  ivt_idx, win_idx;
  logic [5:0]  ivt_server;
  logic [7:0]  ivt_prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  itab_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_data_sel_i(req_dsel), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sel_err_o(sel_err),
    .ivt_upd_o(ivt_upd), .ivt_idx_o(ivt_idx), .ivt_server_o(ivt_server),
    .ivt_prio_o(ivt_prio), .win_chg_o(win_chg), .win_idx_o(win_idx)
  );

  typedef struct {
    int          due;
    logic [63:0] val;
    string       req;
  } exp_t;

  exp_t q_rsp[$];
  exp_t q_ivt[$];
  exp_t q_win[$];
  exp_t q_err[$];

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] m_addr = '0;
  logic [63:0] m_tbl [0:8][0:511];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tmask(logic [3:0] s);
    case (s)
      4'd0, 4'd1: return 7;
      4'd2: return 31;
      4'd3: return 63;
      4'd4: return 15;
      4'd5, 4'd8: return 255;
      4'd6: return 511;
      4'd7: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit tstored(logic [3:0] s);
    return (s == 0) || (s == 1) || (s == 4) || (s == 5) || (s == 6) || (s == 7);
  endfunction

  function automatic logic [63:0] mk_addr(bit ainc, logic [3:0] s, int idx);
    return {ainc, 11'b0, s, 39'b0, idx[8:0]};
  endfunction

  function automatic exp_t mk_exp(logic [63:0] v, string r);
    exp_t e;
    e.due = cyc + 1;
    e.val = v;
    e.req = r;
    return e;
  endfunction

  task automatic drive(bit w, bit ds, logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_dsel  = ds;
    req_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
    end
  endtask

  task automatic wr_addr(logic [63:0] d);
    drive(1'b1, 1'b0, d);
    m_addr = d;
  endtask

  task automatic rd_addr(string r);
    drive(1'b0, 1'b0, '0);
    q_rsp.push_back(mk_exp(m_addr, r));
  endtask

  task automatic data_acc(bit w, logic [63:0] d, string r);
    logic [3:0]  s;
    int          mk, ci;
    logic [63:0] v;
    drive(w, 1'b1, d);
    s  = m_addr[51:48];
    mk = tmask(s);
    if (mk < 0) begin
      q_err.push_back(mk_exp('0, r));
      if (!w) q_rsp.push_back(mk_exp('0, r));
    end else begin
      ci = int'(m_addr[8:0]) & mk;
      if (!w) begin
        q_rsp.push_back(mk_exp(tstored(s) ? m_tbl[s][ci] : 64'h0, r));
      end else if (tstored(s)) begin
        v = (s == 4'd1) ? (d & 64'h0000_0000_FFFF_000F) : d;
        m_tbl[s][ci] = v;
        if (s == 4'd1) q_ivt.push_back(mk_exp({41'b0, 9'(ci), v[31:26], v[23:16]}, r));
        if (s == 4'd4) q_win.push_back(mk_exp({55'b0, 9'(ci)}, r));
      end
      if (m_addr[63]) m_addr[8:0] = 9'((ci + 1) & mk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) begin
        checks++; fails++;
        $display("FAIL R10 ready low act=%0b exp=1", req_ready);
      end
      if (q_rsp.size() > 0 && q_rsp[0].due == cyc) begin
        checks++;
        if (!rsp_valid || rsp_rdata !== q_rsp[0].val) begin
          fails++;
          $display("FAIL %s read act v=%0b %h exp %h", q_rsp[0].req, rsp_valid, rsp_rdata, q_rsp[0].val);
        end
        void'(q_rsp.pop_front());
      end else if (rsp_valid) begin
        checks++; fails++;
        $display("FAIL R10 stray response act=%h exp none", rsp_rdata);
      end
      if (q_ivt.size() > 0 && q_ivt[0].due == cyc) begin
        checks++;
        if (!ivt_upd || {41'b0, ivt_idx, ivt_server, ivt_prio} !== q_ivt[0].val) begin
          fails++;
          $display("FAIL %s ivt strobe act v=%0b %h exp %h", q_ivt[0].req, ivt_upd,
                   {41'b0, ivt_idx, ivt_server, ivt_prio}, q_ivt[0].val);
        end
        void'(q_ivt.pop_front());
      end else if (ivt_upd) begin
        checks++; fails++;
        $display("FAIL R8 stray ivt strobe act=1 exp=0");
      end
      if (q_win.size() > 0 && q_win[0].due == cyc) begin
        checks++;
        if (!win_chg || {55'b0, win_idx} !== q_win[0].val) begin
          fails++;
          $display("FAIL %s win strobe act v=%0b %h exp %h", q_win[0].req, win_chg, win_idx, q_win[0].val);
        end
        void'(q_win.pop_front());
      end else if (win_chg) begin
        checks++; fails++;
        $display("FAIL R9 stray win strobe act=1 exp=0");
      end
      if (q_err.size() > 0 && q_err[0].due == cyc) begin
        checks++;
        if (!sel_err) begin
          fails++;
          $display("FAIL %s error pulse act=0 exp=1", q_err[0].req);
        end
        void'(q_err.pop_front());
      end else if (sel_err) begin
        checks++; fails++;
        $display("FAIL R6 stray error act=1 exp=0");
      end
    end
  end

  task automatic finish_run();
    int left;
    left = q_rsp.size() + q_ivt.size() + q_win.size() + q_err.size();
    checks++;
    if (left != 0) begin
      fails++;
      $display("FAIL R10 pending expectations act=%0d exp=0", left);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 9; s++)
      for (int i = 0; i < 512; i++) m_tbl[s][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 / R11 reset state
    rd_addr("R1");
    data_acc(1'b0, '0, "R11");
    wr_addr(mk_addr(1'b0, 4'd6, 300));
    data_acc(1'b0, '0, "R11");

    // R3 R4 list table wraps at 7, back-to-back
    wr_addr(mk_addr(1'b1, 4'd0, 6));
    data_acc(1'b1, 64'h1111_0000_0000_0006, "R3");
    data_acc(1'b1, 64'h1111_0000_0000_0007, "R3");
    data_acc(1'b1, 64'h1111_0000_0000_0000, "R3");
    rd_addr("R3");
    wr_addr(mk_addr(1'b1, 4'd0, 14));
    data_acc(1'b0, '0, "R2");
    data_acc(1'b0, '0, "R2");
    data_acc(1'b0, '0, "R2");
    rd_addr("R1");

    // R9 window table, no increment, masked index
    wr_addr(mk_addr(1'b0, 4'd4, 9'h1F5));
    data_acc(1'b1, 64'hDEAD_BEEF_0000_0005, "R9");
    rd_addr("R3");
    data_acc(1'b0, '0, "R2");
    wr_addr(mk_addr(1'b1, 4'd4, 15));
    data_acc(1'b1, 64'h0F0F_0F0F_0F0F_0F0F, "R9");
    data_acc(1'b1, 64'h2222_2222_2222_2222, "R9");
    rd_addr("R4");

    // R7 R8 interrupt vector table
    wr_addr(mk_addr(1'b1, 4'd1, 3));
    data_acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    data_acc(1'b1, 64'hABCD_1234_5678_9ABC, "R8");
    wr_addr(mk_addr(1'b1, 4'd1, 11));
    data_acc(1'b0, '0, "R7");
    data_acc(1'b0, '0, "R7");
    wr_addr(mk_addr(1'b1, 4'd1, 7));
    data_acc(1'b1, 64'h0000_0000_0480_0001, "R8");
    data_acc(1'b1, 64'h0000_0000_FC7F_0002, "R8");

    // R4 map, translation and event tables wrap
    wr_addr(mk_addr(1'b1, 4'd5, 255));
    data_acc(1'b1, 64'h5555_0000_0000_00FF, "R4");
    data_acc(1'b1, 64'h5555_0000_0000_0000, "R4");
    wr_addr(mk_addr(1'b1, 4'd6, 511));
    data_acc(1'b1, 64'h6666_0000_0000_01FF, "R4");
    data_acc(1'b1, 64'h6666_0000_0000_0000, "R4");
    wr_addr(mk_addr(1'b1, 4'd7, 3));
    data_acc(1'b1, 64'h7777_0000_0000_0003, "R4");
    data_acc(1'b1, 64'h7777_0000_0000_0000, "R4");
    rd_addr("R4");
    wr_addr(mk_addr(1'b1, 4'd5, 255));
    data_acc(1'b0, '0, "R2");
    data_acc(1'b0, '0, "R2");
    wr_addr(mk_addr(1'b1, 4'd6, 511));
    data_acc(1'b0, '0, "R2");
    data_acc(1'b0, '0, "R2");
    wr_addr(mk_addr(1'b1, 4'd7, 7));
    data_acc(1'b0, '0, "R2");
    data_acc(1'b0, '0, "R2");

    // R5 storage-less selects
    wr_addr(mk_addr(1'b1, 4'd2, 30));
    data_acc(1'b1, 64'h9999_9999_9999_9999, "R5");
    data_acc(1'b1, 64'h9999_9999_9999_9999, "R5");
    data_acc(1'b0, '0, "R5");
    rd_addr("R5");
    wr_addr(mk_addr(1'b1, 4'd3, 63));
    data_acc(1'b0, '0, "R5");
    rd_addr("R5");
    wr_addr(mk_addr(1'b1, 4'd8, 510));
    data_acc(1'b1, 64'h1, "R5");
    data_acc(1'b0, '0, "R5");
    rd_addr("R5");

    // R6 unknown selects
    wr_addr(mk_addr(1'b1, 4'd9, 2));
    data_acc(1'b1, 64'hBAD0_BAD0_BAD0_BAD0, "R6");
    data_acc(1'b0, '0, "R6");
    rd_addr("R6");
    wr_addr(mk_addr(1'b1, 4'd15, 0));
    data_acc(1'b1, 64'hBAD1_BAD1_BAD1_BAD1, "R6");
    rd_addr("R6");
    // tables untouched
    wr_addr(mk_addr(1'b1, 4'd0, 0));
    for (int i = 0; i < 8; i++) data_acc(1'b0, '0, "R6");
    wr_addr(mk_addr(1'b1, 4'd4, 0));
    for (int i = 0; i < 16; i++) data_acc(1'b0, '0, "R6");

    idle(4);
    finish_run();
  end
endmodule